// File: doc/BRIEF.md
# Event Counter with Decade-Prescaled Timer

This block counts pulses arriving on an asynchronous input line in a six-digit BCD counter. The counter is spread over three byte registers, with the least significant digit pair at the lowest address. A two-digit BCD timer advances once for every 1, 100, 10,000 or 1,000,000 counted events. The rate is chosen by a prescale field. The prescale steps come straight from the counter's own digit-pair carries, so no separate divider exists.

Two compares can raise a shared alarm flag. The first matches the counter against a three-byte compare value. The second matches the timer against a one-byte compare value. A timer flag records each timer wrap from 99 to 00. Both flags are sticky and only a software write clears them. Each flag has its own enable onto one active-low interrupt line. Software reaches all state through a plain synchronous write port and a combinational read port.

Register map (address: contents): 0 control/status, 1 to 3 counter bytes (low to high), 4 timer, 5 to 7 counter compare bytes (low to high), 8 timer compare, 9 alarm control. Other addresses read as zero.

Top module: `evtmr_core`

## Requirements
- R1: After reset every register reads 0x00 and irq_n is high.
- R2: When control bits [5:4] are 2'b10 (event mode), each low-to-high transition of evt_in adds one to the counter. The count reads as BCD at addresses 1 (digits 1:0), 2 (digits 3:2) and 3 (digits 5:4). The new count is visible after the third rising clock edge, counting from the edge that first samples evt_in high.
- R3: When control bits [5:4] hold any value other than 2'b10, transitions on evt_in change neither the counter, the timer nor any flag.
- R4: Every counter digit rolls from 9 to 0 and carries into the next digit. The count wraps from 999999 to 000000 without setting any flag.
- R5: Alarm control bits [2:0] select when a counted event also steps the timer. A value of 0 steps it on every event. A value of 1 steps it when digits 1:0 wrap to 00. A value of 2 steps it when digits 3:0 wrap to 0000. A value of 3 steps it when all six digits wrap. Values 4 to 7 never step it.
- R6: The timer at address 4 counts in BCD from 00 to 99. The step after 99 gives 00 and sets the timer flag, control bit 0.
- R7: When alarm control bits [5:4] are 2'b01 and an increment makes the count equal the compare bytes at addresses 5 to 7, the alarm flag (control bit 1) is set.
- R8: When alarm control bit 6 is set and a timer step makes the timer equal the byte at address 8, the alarm flag is set.
- R9: irq_n is low exactly when the alarm flag is set together with alarm control bit 7, or the timer flag is set together with alarm control bit 3. It changes on the same edge as the flag or enable.
- R10: Flags are sticky. A write to address 0 loads wdata[1:0] into them, and nothing else clears them. A hardware set in the same cycle as that write wins.
- R11: Compares are evaluated only on a counter increment or a timer step. A match that persists after the flag is cleared does not set it again. Loading a matching value by a register write does not set it.
- R12: A write to a counter byte in the same cycle as an increment is stored, and that event is dropped entirely, with no count, timer step or flag. A write to the timer in the same cycle as a timer step is stored, and that step and its flags are dropped.
- R13: evt_in passes through a two-flop synchroniser. A level held high for any number of cycles counts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| evt_in | input | 1 | Asynchronous event pulse line |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Register writes appear on rdata after the next rising edge. A counted event shows its effect on the counter, timer, flags and irq_n three edges after evt_in is first sampled high, because two synchroniser stages and the edge detector come before the state update. The interrupt follows its flag on the same edge. The bench drives inputs on the falling edge and samples 1 ns after each rising edge, so each result is read in the first cycle it is due. A behavioural model built on decimal integers and a delayed history of evt_in predicts rdata and irq_n on every clock. Directed reads with fixed expected values cover each corner case, and the write-versus-increment collision is placed on the exact edge where the event lands.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
    // control/status register fields
    localparam int CTL_TFLAG = 0;
    localparam int CTL_AFLAG = 1;
    localparam int CTL_FN_LO = 4;
    localparam int CTL_FN_HI = 5;
    localparam logic [1:0] FN_EVENT = 2'b10;

    // alarm control register fields
    localparam int ACT_PSC_HI = 2;
    localparam int ACT_TIEN   = 3;
    localparam int ACT_ALM_LO = 4;
    localparam int ACT_ALM_HI = 5;
    localparam int ACT_TALM   = 6;
    localparam int ACT_AIEN   = 7;
    localparam logic [1:0] ALM_EVENT = 2'b01;
endpackage

// File: rtl/evtmr_sync.sv
module evtmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/evtmr_bcd_inc.sv
module evtmr_bcd_inc #(
    parameter int DIGITS = 2
) (
    input  logic [4*DIGITS-1:0] val_i,
    output logic [4*DIGITS-1:0] sum_o,
    output logic [DIGITS-1:0]   wrap_o
);
    logic [DIGITS:0] carry;
    assign carry[0] = 1'b1;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [3:0] dig;
        assign dig         = val_i[4*g +: 4];
        assign wrap_o[g]   = carry[g] && (dig >= 4'd9);
        assign sum_o[4*g +: 4] = !carry[g] ? dig : ((dig >= 4'd9) ? 4'd0 : dig + 4'd1);
        assign carry[g+1]  = wrap_o[g];
    end
endmodule

// File: rtl/evtmr_core.sv
module evtmr_core
    import evtmr_pkg::*;
#(
    parameter int CNT_BYTES   = 3,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(2*CNT_BYTES + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              evt_in,
    output logic              irq_n
);
    localparam int CNT_DIGITS = 2 * CNT_BYTES;
    localparam int CNT_W      = 8 * CNT_BYTES;
    localparam int A_CTRL     = 0;
    localparam int A_CNT0     = 1;
    localparam int A_TMR      = A_CNT0 + CNT_BYTES;
    localparam int A_CMP0     = A_TMR + 1;
    localparam int A_TCMP     = A_CMP0 + CNT_BYTES;
    localparam int A_ACTL     = A_TCMP + 1;

    typedef struct packed {
        logic [7:0]       ctrl;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       tmr;
        logic [CNT_W-1:0] cmp;
        logic [7:0]       tcmp;
        logic [7:0]       actl;
    } state_t;

    state_t d, q;

    logic                  evt_pulse;
    logic [CNT_W-1:0]      cnt_inc;
    logic [CNT_DIGITS-1:0] cnt_wrap;
    logic [7:0]            tmr_inc;
    logic [1:0]            tmr_wrap;
    logic                  cnt_wr, tmr_wr, evt_go, tmr_go, tick, set_a, set_t;

    evtmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(evt_in),
        .rise_o (evt_pulse)
    );

    evtmr_bcd_inc #(.DIGITS(CNT_DIGITS)) u_cnt_inc (
        .val_i (q.cnt),
        .sum_o (cnt_inc),
        .wrap_o(cnt_wrap)
    );

    evtmr_bcd_inc #(.DIGITS(2)) u_tmr_inc (
        .val_i (q.tmr),
        .sum_o (tmr_inc),
        .wrap_o(tmr_wrap)
    );

    always_comb begin
        d      = q;
        cnt_wr = 1'b0;
        tick   = 1'b0;
        set_a  = 1'b0;
        set_t  = 1'b0;

        // software writes
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (wr_en && int'(addr) == A_CNT0 + b) begin
                d.cnt[8*b +: 8] = wdata;
                cnt_wr          = 1'b1;
            end
            if (wr_en && int'(addr) == A_CMP0 + b) d.cmp[8*b +: 8] = wdata;
        end
        tmr_wr = wr_en && int'(addr) == A_TMR;
        if (tmr_wr) d.tmr = wdata;
        if (wr_en && int'(addr) == A_TCMP) d.tcmp = wdata;
        if (wr_en && int'(addr) == A_ACTL) d.actl = wdata;
        if (wr_en && int'(addr) == A_CTRL) d.ctrl = wdata;

        // decade prescale taken from digit-pair carries
        if (q.actl[ACT_PSC_HI:0] == 3'd0) tick = 1'b1;
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (int'(q.actl[ACT_PSC_HI:0]) == b + 1) tick = cnt_wrap[2*b+1];
        end

        evt_go = evt_pulse && (q.ctrl[CTL_FN_HI:CTL_FN_LO] == FN_EVENT) && !cnt_wr;
        tmr_go = evt_go && tick && !tmr_wr;

        if (evt_go) begin
            d.cnt = cnt_inc;
            if (q.actl[ACT_ALM_HI:ACT_ALM_LO] == ALM_EVENT && cnt_inc == q.cmp) set_a = 1'b1;
        end
        if (tmr_go) begin
            d.tmr = tmr_inc;
            set_t = tmr_wrap[1];
            if (q.actl[ACT_TALM] && tmr_inc == q.tcmp) set_a = 1'b1;
        end

        d.ctrl[CTL_TFLAG] = d.ctrl[CTL_TFLAG] | set_t;
        d.ctrl[CTL_AFLAG] = d.ctrl[CTL_AFLAG] | set_a;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = 8'h00;
        if (int'(addr) == A_CTRL) rdata = q.ctrl;
        if (int'(addr) == A_TMR)  rdata = q.tmr;
        if (int'(addr) == A_TCMP) rdata = q.tcmp;
        if (int'(addr) == A_ACTL) rdata = q.actl;
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (int'(addr) == A_CNT0 + b) rdata = q.cnt[8*b +: 8];
            if (int'(addr) == A_CMP0 + b) rdata = q.cmp[8*b +: 8];
        end
    end

    assign irq_n = !((q.ctrl[CTL_AFLAG] && q.actl[ACT_AIEN]) ||
                     (q.ctrl[CTL_TFLAG] && q.actl[ACT_TIEN]));
endmodule

// File: rtl/evtmr_chk.sv
module evtmr_chk #(
    parameter int CNT_BYTES = 3,
    localparam int ADDR_W   = $clog2(2*CNT_BYTES + 4)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      addr,
    input logic [7:0]             wdata,
    input logic                   irq_n,
    input logic                   evt_pulse,
    input logic [7:0]             ctrl_q,
    input logic [8*CNT_BYTES-1:0] cnt_q,
    input logic [7:0]             tmr_q
);
    localparam int A_CTRL = 0;
    localparam int A_CNT0 = 1;
    localparam int A_TMR  = A_CNT0 + CNT_BYTES;
    localparam int A_ACTL = 2*CNT_BYTES + 3;

    logic cnt_wr, ctrl_wr, actl_wr;
    assign cnt_wr  = wr_en && int'(addr) >= A_CNT0 && int'(addr) < A_CNT0 + CNT_BYTES;
    assign ctrl_wr = wr_en && int'(addr) == A_CTRL;
    assign actl_wr = wr_en && int'(addr) == A_ACTL;

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_pulse && !cnt_wr) |=> $stable(cnt_q)); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1] && !ctrl_wr) |=> ctrl_q[1]); // R10

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(ctrl_wr || actl_wr)); // R9

    AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == A_CNT0) |=> cnt_q[7:0] == $past(wdata)); // R12

    AST_TFLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[0]) |-> ($past(tmr_q) == 8'h99 || $past(ctrl_wr && wdata[0]))); // R6

    AST_TMR_STEP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_pulse && !(wr_en && int'(addr) == A_TMR)) |=> $stable(tmr_q)); // R5

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> !evt_pulse); // R13
endmodule

bind evtmr_core evtmr_chk #(.CNT_BYTES(CNT_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq_n    (irq_n),
    .evt_pulse(evt_pulse),
    .ctrl_q   (q.ctrl),
    .cnt_q    (q.cnt),
    .tmr_q    (q.tmr)
);

// File: tb/evtmr_core_bench.sv
module evtmr_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic       evt_in = 1'b0;
    logic [7:0] rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    evtmr_core u_evtmr_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_in(evt_in), .irq_n(irq_n)
    );

    // ---------------- behavioural reference ----------------
    int         m_cnt, m_tmr, m_cmp, m_tcmp;
    logic [7:0] m_ctrl, m_actl;
    bit         hist[3];

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + v % 10);
    endfunction

    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int pw100(int k);
        int r = 1;
        for (int i = 0; i < k; i++) r = r * 100;
        return r;
    endfunction

    function automatic logic [7:0] m_read(logic [3:0] a);
        case (a)
            4'd0: return m_ctrl;
            4'd1, 4'd2, 4'd3: return to_bcd((m_cnt / pw100(int'(a) - 1)) % 100);
            4'd4: return to_bcd(m_tmr);
            4'd5, 4'd6, 4'd7: return to_bcd((m_cmp / pw100(int'(a) - 5)) % 100);
            4'd8: return to_bcd(m_tcmp);
            4'd9: return m_actl;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int put_pair(int v, int k, logic [7:0] b);
        int p = pw100(k);
        return v - ((v / p) % 100) * p + from_bcd(b) * p;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tmr = 0; m_cmp = 0; m_tcmp = 0;
            m_ctrl = 8'h00; m_actl = 8'h00;
            hist[0] = 0; hist[1] = 0; hist[2] = 0;
        end else begin
            bit pulse, cw, tw, go, tk, sa, st;
            int o_tmr, o_cmp, o_tcmp, nc, nt;
            logic [7:0] o_ctrl, o_actl;
            pulse = hist[1] && !hist[2];
            o_ctrl = m_ctrl; o_actl = m_actl; o_tmr = m_tmr; o_cmp = m_cmp; o_tcmp = m_tcmp;
            cw = wr_en && addr >= 4'd1 && addr <= 4'd3;
            tw = wr_en && addr == 4'd4;
            if (wr_en) begin
                case (addr)
                    4'd0: m_ctrl = wdata;
                    4'd1, 4'd2, 4'd3: m_cnt = put_pair(m_cnt, int'(addr) - 1, wdata);
                    4'd4: m_tmr = from_bcd(wdata);
                    4'd5, 4'd6, 4'd7: m_cmp = put_pair(m_cmp, int'(addr) - 5, wdata);
                    4'd8: m_tcmp = from_bcd(wdata);
                    4'd9: m_actl = wdata;
                    default: ;
                endcase
            end
            sa = 0; st = 0;
            go = pulse && o_ctrl[5:4] == 2'b10 && !cw;
            if (go) begin
                nc = (m_cnt + 1) % 1000000;
                case (o_actl[2:0])
                    3'd0: tk = 1;
                    3'd1: tk = (nc % 100) == 0;
                    3'd2: tk = (nc % 10000) == 0;
                    3'd3: tk = nc == 0;
                    default: tk = 0;
                endcase
                if (o_actl[5:4] == 2'b01 && nc == o_cmp) sa = 1;
                m_cnt = nc;
                if (tk && !tw) begin
                    nt = (o_tmr + 1) % 100;
                    if (o_tmr == 99) st = 1;
                    if (o_actl[6] && nt == o_tcmp) sa = 1;
                    m_tmr = nt;
                end
            end
            if (st) m_ctrl[0] = 1'b1;
            if (sa) m_ctrl[1] = 1'b1;
            hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = evt_in;
        end
    end

    // ---------------- reporting ----------------
    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, got, exp);
        end
    endtask

    // model compare on every clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R2 model rdata", rdata, m_read(addr));
            chk("R9 model irq_n", {7'd0, irq_n},
                {7'd0, !((m_ctrl[1] && m_actl[7]) || (m_ctrl[0] && m_actl[3]))});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            report();
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [3:0] a, logic [7:0] exp);
        @(negedge clk); addr = a;
        @(posedge clk); #1;
        chk(tag, rdata, exp);
    endtask

    task automatic irq_chk(string tag, logic exp);
        @(posedge clk); #1;
        chk(tag, {7'd0, irq_n}, {7'd0, exp});
    endtask

    task automatic pulse();
        @(negedge clk); evt_in = 1'b1;
        repeat (2) @(negedge clk);
        evt_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 10; a++) rd_chk("R1 reset", 4'(a), 8'h00);
        irq_chk("R1 irq_n reset", 1'b1);

        // R2 counting, prescale 0 steps timer each event
        wr(4'd0, 8'h20);
        repeat (3) pulse();
        rd_chk("R2 count", 4'd1, 8'h03);
        rd_chk("R5 sel0 timer", 4'd4, 8'h03);

        // R3 outside event mode
        wr(4'd0, 8'h00);
        pulse();
        rd_chk("R3 count held", 4'd1, 8'h03);
        rd_chk("R3 timer held", 4'd4, 8'h03);

        // R4/R5 digit carry, prescale 1
        wr(4'd0, 8'h20); wr(4'd9, 8'h01); wr(4'd1, 8'h98); wr(4'd4, 8'h00);
        repeat (3) pulse();
        rd_chk("R4 low byte", 4'd1, 8'h01);
        rd_chk("R4 mid byte", 4'd2, 8'h01);
        rd_chk("R5 sel1 timer", 4'd4, 8'h01);

        // prescale 2
        wr(4'd9, 8'h02); wr(4'd1, 8'h99); wr(4'd2, 8'h99);
        pulse();
        rd_chk("R4 high byte", 4'd3, 8'h01);
        rd_chk("R5 sel2 timer", 4'd4, 8'h02);

        // prescale 3 and full wrap
        wr(4'd9, 8'h03); wr(4'd1, 8'h99); wr(4'd2, 8'h99); wr(4'd3, 8'h99);
        pulse();
        rd_chk("R4 wrap high", 4'd3, 8'h00);
        rd_chk("R4 wrap low", 4'd1, 8'h00);
        rd_chk("R5 sel3 timer", 4'd4, 8'h03);
        rd_chk("R4 no flag on wrap", 4'd0, 8'h20);

        // prescale 7 holds the timer
        wr(4'd9, 8'h07);
        pulse();
        rd_chk("R5 sel7 count", 4'd1, 8'h01);
        rd_chk("R5 sel7 timer", 4'd4, 8'h03);

        // R6 timer overflow, R9 interrupt, R10 sticky
        wr(4'd9, 8'h08); wr(4'd4, 8'h99);
        pulse();
        rd_chk("R6 timer wrap", 4'd4, 8'h00);
        rd_chk("R6 timer flag", 4'd0, 8'h21);
        irq_chk("R9 timer irq", 1'b0);
        pulse();
        rd_chk("R10 flag sticky", 4'd0, 8'h21);
        wr(4'd0, 8'h20);
        irq_chk("R9 irq released", 1'b1);

        // R7 event alarm
        wr(4'd9, 8'h90); wr(4'd5, 8'h10); wr(4'd6, 8'h00); wr(4'd7, 8'h00);
        wr(4'd1, 8'h08);
        pulse();
        rd_chk("R7 no match yet", 4'd0, 8'h20);
        pulse();
        rd_chk("R7 event alarm", 4'd0, 8'h22);
        irq_chk("R9 alarm irq", 1'b0);

        // R11 match persists / loaded by write
        wr(4'd0, 8'h20);
        repeat (5) @(negedge clk);
        rd_chk("R11 no reset on persist", 4'd0, 8'h20);
        wr(4'd1, 8'h10);
        rd_chk("R11 no set on write", 4'd0, 8'h20);

        // R12 write lands on the increment edge
        @(negedge clk); evt_in = 1'b1;
        @(negedge clk);
        @(negedge clk); evt_in = 1'b0; wr_en = 1'b1; addr = 4'd1; wdata = 8'h55;
        @(negedge clk); wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rd_chk("R12 write wins", 4'd1, 8'h55);
        rd_chk("R12 timer not stepped", 4'd4, 8'h03);

        // R8 timer alarm
        wr(4'd9, 8'hC0); wr(4'd8, 8'h05); wr(4'd4, 8'h03);
        pulse();
        rd_chk("R8 no match yet", 4'd0, 8'h20);
        pulse();
        rd_chk("R8 timer alarm", 4'd0, 8'h22);

        // R13 long level counts once
        wr(4'd0, 8'h20);
        @(negedge clk); evt_in = 1'b1;
        repeat (20) @(negedge clk);
        evt_in = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk("R13 single count", 4'd1, 8'h58);

        repeat (3) @(negedge clk);
        report();
    end
endmodule